// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves words between system memory and a single internal peripheral port. Software describes up to two buffers at once through a small register bus. Each buffer has a descriptor slot holding a byte count and a base address. The slots are filled in strict alternation, starting at slot 0 each time the channel is enabled. Writing a slot's base address arms that slot. For every request from the peripheral, the channel performs one word access to memory and then acknowledges the peripheral. In the default transmit variant the word is read from memory and presented to the peripheral. In the receive variant the peripheral's word is written to memory.

A four-state controller counts how many buffers are armed:
- IDLE: the channel is inactive.
- STALL: the channel is active with no buffer armed.
- ON: one buffer is armed.
- NEXT: two buffers are armed.

The transitions are:
- IDLE→STALL (enable committed).
- STALL→ON (arm).
- ON→NEXT (arm).
- NEXT→ON (active buffer completes; the other slot takes over).
- ON→STALL (active buffer completes with nothing queued).
- ON→ON (completion and arm in the same cycle).
- STALL→IDLE (enable removed).

The stall and next-free-buffer conditions follow directly from the state. A transfer error is latched. Each of the three can drive the interrupt line under its own enable bit.

Control writes are staged. A written control value only reaches the controller when the control register is next read. This lets software order a shutdown: first it drops the buffer interrupt enables and lets the armed buffer drain, then it clears the channel enable.

Top module: `pbuf_dma_chan`

## Requirements
- R1: After reset the status state field (bits [5:4] at 0x0C) reads 0 (IDLE), the control register (0x00) reads 0, the remaining count (0x14) reads 0 and `irq` is low.
- R2: A write to control (0x00) has no effect on the controller until control is read. That read returns the value last written (bits 0, 1, 3 and 4 are stored) and commits it.
- R3: With the committed enable bit 4 set, IDLE moves to STALL one cycle later. The state encoding at status [5:4] is 0 IDLE, 1 STALL, 2 ON, 3 NEXT.
- R4: Slots are armed alternately from slot 0. Slot 0 has its count at 0x20 and base at 0x24. Slot 1 has its count at 0x30 and base at 0x34.
  - Writing the base of the slot whose turn it is, while in STALL or ON, arms it: STALL→ON, ON→NEXT.
  - Writing the other slot's base arms nothing.
- R5: Each peripheral request taken in ON or NEXT produces one memory access. The address is the active base plus 4 times the number of words already moved. An acknowledge follows, and in transmit mode `per_wdata` carries the word read.
- R6: The remaining count loads from the slot's byte count when the buffer becomes active. It drops by 4 on each completed transfer.
- R7: When the last word of a buffer completes:
  - In NEXT, the channel enters ON and reloads the count and address from the other slot.
  - In ON, the channel enters STALL.
- R8: The interrupt register (0x04) has the following bits:
  - Bit 0 is set exactly in STALL.
  - Bit 1 is set exactly in ON.
  - Bit 3 is the latched error flag.
- R9: `irq` is the OR over bits 0, 1 and 3 of each flag ANDed with the control enable in the same bit position.
- R10: The error flag sets when `err_in` is high while a transfer is in progress. A high `err_in` with no transfer in progress leaves it unchanged. Writing 1 to bit 3 of 0x04 clears it.
- R11: In IDLE and STALL, peripheral requests are ignored: no memory access and no acknowledge.
- R12: Clearing the enable while in ON lets the armed buffer finish. The channel then passes through STALL to IDLE. In IDLE, base writes arm nothing.
- R13: The port select register (0x08) drives `per_sel` and reads back its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (commits staged control) |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Access is a write (receive variant) |
| mem_addr | output | DW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_done | input | 1 | Memory access completes |
| mem_rdata | input | DW | Memory read data |
| per_sel | output | PORT_W | Selected peripheral port |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Peripheral transfer acknowledge |
| per_wdata | output | DW | Word delivered to the peripheral |
| per_rdata | input | DW | Word supplied by the peripheral |
| err_in | input | 1 | Transfer error indication |
| irq | output | 1 | Channel interrupt |

## Verification
The main flow is swept over every pair of buffer lengths from one to three words for slots 0 and 1. Each pair is queued back to back, which separates a completion that hands over to the other slot from one that drops the channel to STALL. It also catches any off-by-one in the remaining count or in the address stepping. A lone buffer run with only the next-free-buffer interrupt enabled separates the two state-derived flags on the `irq` line. Error pulses are placed both inside and outside a transfer, so a flag that latches unconditionally is told apart from a correct one. Wrong-slot base writes, staged control without a commit read, and requests in IDLE and STALL confirm that those stimuli change nothing visible.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_STALL = 2'd1,
        CH_ON    = 2'd2,
        CH_NEXT  = 2'd3
    } ch_state_t;

    typedef enum logic [1:0] {
        XF_WAIT = 2'd0,
        XF_MEM  = 2'd1,
        XF_ACK  = 2'd2
    } xf_state_t;

    localparam int NSLOT       = 2;
    localparam int A_CTRL      = 'h00;
    localparam int A_INT       = 'h04;
    localparam int A_PORT      = 'h08;
    localparam int A_STAT      = 'h0C;
    localparam int A_REM       = 'h14;
    localparam int A_SLOT0     = 'h20;
    localparam int SLOT_STRIDE = 'h10;

    localparam int B_STALL_EN = 0;
    localparam int B_NFB_EN   = 1;
    localparam int B_ERR_EN   = 3;
    localparam int B_RUN      = 4;
    localparam int ST_LSB     = 4;

endpackage

// File: rtl/pbd_regs.sv
module pbd_regs
    import pbd_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int PORT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    input  ch_state_t                 st,
    input  logic                      fill_ptr,
    input  logic [DW-1:0]             rem,
    input  logic                      err_hit,
    output logic                      run,
    output logic                      arm,
    output logic [NSLOT-1:0][DW-1:0]  cnt_q,
    output logic [NSLOT-1:0][DW-1:0]  base_q,
    output logic [PORT_W-1:0]         port_q,
    output logic [3:0]                int_flags,
    output logic                      irq
);

    logic [4:0]       ctrl_pend;
    logic [4:0]       ctrl_live;
    logic             err_q;
    logic [NSLOT-1:0] base_hit;

    // staged control: the controller only sees a value after it is read back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_pend <= '0;
            ctrl_live <= '0;
        end else begin
            if (wr && addr == AW'(A_CTRL))
                ctrl_pend <= {wdata[B_RUN], wdata[B_ERR_EN], 1'b0,
                              wdata[B_NFB_EN], wdata[B_STALL_EN]};
            if (rd && addr == AW'(A_CTRL))
                ctrl_live <= ctrl_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            port_q <= '0;
        else if (wr && addr == AW'(A_PORT))
            port_q <= wdata[PORT_W-1:0];
    end

    // error flag: set by a faulted transfer, cleared by writing 1 to its bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (err_hit)
            err_q <= 1'b1;
        else if (wr && addr == AW'(A_INT) && wdata[B_ERR_EN])
            err_q <= 1'b0;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int CNT_A  = A_SLOT0 + s * SLOT_STRIDE;
        localparam int BASE_A = CNT_A + 4;
        assign base_hit[s] = wr && addr == AW'(BASE_A);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[s]  <= '0;
                base_q[s] <= '0;
            end else begin
                if (wr && addr == AW'(CNT_A))
                    cnt_q[s] <= wdata;
                if (base_hit[s])
                    base_q[s] <= wdata;
            end
        end
    end

    assign run = ctrl_live[4];
    assign arm = base_hit[fill_ptr] && (st == CH_STALL || st == CH_ON);

    assign int_flags = {err_q, 1'b0, st == CH_ON, st == CH_STALL};
    assign irq = (int_flags[B_STALL_EN] && ctrl_live[0]) ||
                 (int_flags[B_NFB_EN]   && ctrl_live[1]) ||
                 (int_flags[B_ERR_EN]   && ctrl_live[3]);

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(A_CTRL):  rdata = DW'({ctrl_pend[4:3], 1'b0, ctrl_pend[1:0]});
            AW'(A_INT):   rdata = DW'(int_flags);
            AW'(A_PORT):  rdata = DW'(port_q);
            AW'(A_STAT):  rdata = DW'({st, 4'b0});
            AW'(A_REM):   rdata = rem;
            AW'(A_SLOT0):                     rdata = cnt_q[0];
            AW'(A_SLOT0 + 4):                 rdata = base_q[0];
            AW'(A_SLOT0 + SLOT_STRIDE):       rdata = cnt_q[1];
            AW'(A_SLOT0 + SLOT_STRIDE + 4):   rdata = base_q[1];
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbd_fsm.sv
module pbd_fsm
    import pbd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      arm,
    input  logic      done,
    output ch_state_t st,
    output logic      fill_ptr,
    output logic      act_ptr,
    output logic      load,
    output logic      load_arm
);

    ch_state_t st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE:  if (run) st_nx = CH_STALL;
            CH_STALL: begin
                if (arm)       st_nx = CH_ON;
                else if (!run) st_nx = CH_IDLE;
            end
            CH_ON: begin
                if (done && arm) st_nx = CH_ON;
                else if (done)   st_nx = CH_STALL;
                else if (arm)    st_nx = CH_NEXT;
            end
            CH_NEXT:  if (done) st_nx = CH_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    // slot pointers: fill advances on each arm, active on each completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_ptr <= 1'b0;
            act_ptr  <= 1'b0;
        end else if (st == CH_IDLE) begin
            fill_ptr <= 1'b0;
            act_ptr  <= 1'b0;
        end else begin
            if (arm)  fill_ptr <= ~fill_ptr;
            if (done) act_ptr  <= ~act_ptr;
        end
    end

    always_comb begin
        load_arm = arm && (st == CH_STALL || (st == CH_ON && done));
        load     = load_arm || (st == CH_NEXT && done);
    end

endmodule

// File: rtl/pbd_xfer.sv
module pbd_xfer
    import pbd_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BPX = 4,
    parameter bit RX  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          load,
    input  logic [DW-1:0] load_cnt,
    input  logic [DW-1:0] load_base,
    input  logic          per_req,
    input  logic [DW-1:0] per_rdata,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_rdata,
    input  logic          err_in,
    output logic          mem_req,
    output logic          mem_wr,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          per_ack,
    output logic [DW-1:0] per_wdata,
    output logic          done,
    output logic [DW-1:0] rem,
    output logic          err_hit
);

    localparam logic [DW-1:0] STEP = DW'(BPX);

    xf_state_t     xf, xf_nx;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          start;
    logic          cap;

    assign start = (xf == XF_WAIT) && per_req && active;

    always_comb begin
        xf_nx = xf;
        unique case (xf)
            XF_WAIT: if (start)    xf_nx = XF_MEM;
            XF_MEM:  if (mem_done) xf_nx = XF_ACK;
            XF_ACK:                xf_nx = XF_WAIT;
            default:               xf_nx = XF_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xf <= XF_WAIT;
        else        xf <= xf_nx;
    end

    // data word: from the peripheral when receiving, from memory when sending
    assign cap = RX ? start : (xf == XF_MEM && mem_done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (cap)
            data_q <= RX ? per_rdata : mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem    <= '0;
            addr_q <= '0;
        end else if (load) begin
            rem    <= load_cnt;
            addr_q <= load_base;
        end else if (xf == XF_ACK) begin
            rem    <= (rem > STEP) ? rem - STEP : '0;
            addr_q <= addr_q + STEP;
        end
    end

    assign mem_req   = (xf == XF_MEM);
    assign mem_wr    = RX;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
    assign per_ack   = (xf == XF_ACK);
    assign per_wdata = data_q;
    assign done      = (xf == XF_ACK) && (rem <= STEP);
    assign err_hit   = err_in && (xf != XF_WAIT);

endmodule

// File: rtl/pbuf_dma_chan.sv
module pbuf_dma_chan
    import pbd_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int PORT_W = 4,
    parameter int BPX    = 4,
    parameter bit RX     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_done,
    input  logic [DW-1:0]     mem_rdata,
    output logic [PORT_W-1:0] per_sel,
    input  logic              per_req,
    output logic              per_ack,
    output logic [DW-1:0]     per_wdata,
    input  logic [DW-1:0]     per_rdata,
    input  logic              err_in,
    output logic              irq
);

    ch_state_t                st;
    logic                     fill_ptr, act_ptr;
    logic                     run, arm, done, load, load_arm, err_hit;
    logic [DW-1:0]            rem;
    logic [NSLOT-1:0][DW-1:0] cnt_q, base_q;
    logic [3:0]               int_flags;
    logic [DW-1:0]            load_cnt, load_base;
    logic                     ld_slot;

    pbd_regs #(.AW(AW), .DW(DW), .PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata),
        .st(st), .fill_ptr(fill_ptr), .rem(rem), .err_hit(err_hit),
        .run(run), .arm(arm), .cnt_q(cnt_q), .base_q(base_q),
        .port_q(per_sel), .int_flags(int_flags), .irq(irq)
    );

    pbd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run(run), .arm(arm), .done(done),
        .st(st), .fill_ptr(fill_ptr), .act_ptr(act_ptr),
        .load(load), .load_arm(load_arm)
    );

    // an arm loads the slot being written (base arrives this cycle);
    // a hand-over loads the slot behind the one just finished
    assign ld_slot   = load_arm ? fill_ptr : ~act_ptr;
    assign load_cnt  = cnt_q[ld_slot];
    assign load_base = load_arm ? reg_wdata : base_q[ld_slot];

    pbd_xfer #(.DW(DW), .BPX(BPX), .RX(RX)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .active(st == CH_ON || st == CH_NEXT),
        .load(load), .load_cnt(load_cnt), .load_base(load_base),
        .per_req(per_req), .per_rdata(per_rdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata), .err_in(err_in),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .per_ack(per_ack), .per_wdata(per_wdata),
        .done(done), .rem(rem), .err_hit(err_hit)
    );

endmodule

// File: rtl/pbd_chk.sv
module pbd_chk
    import pbd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] st,
    input logic       arm,
    input logic       done,
    input logic       mem_req,
    input logic       mem_done,
    input logic       per_ack,
    input logic [3:0] int_flags,
    input logic       err_in
);

    assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st == CH_IDLE |=> (st == CH_IDLE || st == CH_STALL));

    assert_arm_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_STALL && arm) |=> st == CH_ON);

    assert_arm_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ON && arm && !done) |=> st == CH_NEXT);

    assert_next_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_NEXT && done) |=> st == CH_ON);

    assert_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ON && done && !arm) |=> st == CH_STALL);

    assert_req_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (st == CH_ON || st == CH_NEXT));

    assert_ack_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done) |=> per_ack);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flags[3]) |-> $past(err_in));

    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_flags[1:0]));

endmodule

bind pbuf_dma_chan pbd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .arm(arm), .done(done),
    .mem_req(mem_req), .mem_done(mem_done), .per_ack(per_ack),
    .int_flags(int_flags), .err_in(err_in)
);

// File: tb/sim_pbuf_dma_chan.sv
module sim_pbuf_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_wr, mem_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  per_sel;
    logic        per_req = 1'b0, per_ack;
    logic [31:0] per_wdata;
    logic [31:0] per_rdata = '0;
    logic        err_in = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    // memory answers in the request cycle; data is a function of the address
    assign mem_done  = mem_req;
    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

    pbuf_dma_chan u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .per_sel(per_sel), .per_req(per_req), .per_ack(per_ack),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .err_in(err_in), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic state_is(input string tag, input logic [1:0] exp);
        logic [31:0] v;
        rd(8'h0C, v);
        check(tag, {30'b0, v[5:4]}, {30'b0, exp});
    endtask

    task automatic xfer(input logic e, output logic [31:0] a, output logic [31:0] d,
                        output logic ok);
        @(negedge clk);
        per_req = 1'b1; err_in = e; ok = 1'b0; a = '0; d = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req) a = mem_addr;
            if (per_ack) begin d = per_wdata; ok = 1'b1; break; end
        end
        per_req = 1'b0; err_in = 1'b0;
    endtask

    // hold a request and report whether any memory access or ack appears
    task automatic idle_req(output logic seen);
        seen = 1'b0;
        @(negedge clk);
        per_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (mem_req || per_ack) seen = 1'b1;
        end
        per_req = 1'b0;
    endtask

    task automatic commit_ctrl(input logic [31:0] v);
        logic [31:0] r;
        wr(8'h00, v);
        rd(8'h00, r);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v, a, d;
        logic ok, seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        state_is("R1 state", 2'd0);
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h14, v); check("R1 remaining", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R13 port select
        wr(8'h08, 32'h5);
        check("R13 per_sel", {28'b0, per_sel}, 32'h5);
        rd(8'h08, v); check("R13 readback", v, 32'h5);

        // R2 staged control: enable + stall irq + error irq
        wr(8'h00, 32'h19);
        repeat (3) @(negedge clk);
        state_is("R2 no commit without read", 2'd0);
        rd(8'h00, v); check("R2 readback", v, 32'h19);
        state_is("R3 idle->stall", 2'd1);
        rd(8'h04, v); check("R8 stall flag", v, 32'h1);
        check("R9 irq on stall", {31'b0, irq}, 32'h1);

        // R11 requests ignored in STALL
        idle_req(seen); check("R11 stall ignores req", {31'b0, seen}, 32'h0);

        // R4 wrong slot base arms nothing
        wr(8'h30, 32'd8); wr(8'h34, 32'h0000_7000);
        state_is("R4 wrong slot no arm", 2'd1);

        // sweep of buffer lengths (words) for both slots
        for (int na = 1; na <= 3; na++) begin
            for (int nb = 1; nb <= 3; nb++) begin
                logic [31:0] b0, b1;
                b0 = 32'h1000 + 32'(na) * 32'h100;
                b1 = 32'h8000 + 32'(nb) * 32'h100;
                wr(8'h20, 32'(4 * na)); wr(8'h24, b0);
                state_is("R4 stall->on", 2'd2);
                check("R9 irq off in on", {31'b0, irq}, 32'h0);
                rd(8'h14, v); check("R6 load", v, 32'(4 * na));
                wr(8'h30, 32'(4 * nb)); wr(8'h34, b1);
                state_is("R4 on->next", 2'd3);
                rd(8'h04, v); check("R8 flags in next", v, 32'h0);
                for (int k = 0; k < na; k++) begin
                    xfer(1'b0, a, d, ok);
                    check("R5 ack", {31'b0, ok}, 32'h1);
                    check("R5 addr slot0", a, b0 + 32'(4 * k));
                    check("R5 data slot0", d, (b0 + 32'(4 * k)) ^ 32'h5A5A_0000);
                    rd(8'h14, v);
                    check(k == na - 1 ? "R7 reload" : "R6 count",
                          v, k == na - 1 ? 32'(4 * nb) : 32'(4 * (na - k - 1)));
                end
                state_is("R7 next->on", 2'd2);
                rd(8'h04, v); check("R8 nfb flag", v, 32'h2);
                for (int k = 0; k < nb; k++) begin
                    xfer(1'b0, a, d, ok);
                    check("R5 addr slot1", a, b1 + 32'(4 * k));
                    check("R5 data slot1", d, (b1 + 32'(4 * k)) ^ 32'h5A5A_0000);
                end
                state_is("R7 on->stall", 2'd1);
            end
        end

        // R9 with only next-free-buffer irq enabled (plus error)
        commit_ctrl(32'h1A);
        check("R9 stall masked", {31'b0, irq}, 32'h0);
        wr(8'h20, 32'd4); wr(8'h24, 32'h0000_2000);
        check("R9 nfb irq", {31'b0, irq}, 32'h1);
        xfer(1'b0, a, d, ok);
        @(negedge clk);
        check("R9 irq after drain", {31'b0, irq}, 32'h0);

        // R10 error latch (fill pointer now at slot 1)
        wr(8'h30, 32'd8); wr(8'h34, 32'h0000_3000);
        state_is("R4 slot1 arm", 2'd2);
        xfer(1'b1, a, d, ok);
        rd(8'h04, v); check("R10 error latched", v, 32'hA);
        check("R10 irq error", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h8);
        rd(8'h04, v); check("R10 w1c", v, 32'h2);
        @(negedge clk); err_in = 1'b1;
        repeat (2) @(negedge clk); err_in = 1'b0;
        rd(8'h04, v); check("R10 err outside xfer", v, 32'h2);

        // R12 disable drain: irq enables off, then enable off
        commit_ctrl(32'h10);
        commit_ctrl(32'h0);
        state_is("R12 still on", 2'd2);
        xfer(1'b0, a, d, ok);
        check("R12 last word", a, 32'h0000_3004);
        repeat (2) @(negedge clk);
        state_is("R12 stall->idle", 2'd0);
        wr(8'h20, 32'd4); wr(8'h24, 32'h0000_4000);
        state_is("R12 no arm in idle", 2'd0);
        idle_req(seen); check("R11 idle ignores req", {31'b0, seen}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule